// File: doc/BRIEF.md
# Capture Buffer Write Controller

This block feeds one write port of a capture RAM from a 32-bit word source that produces a new value every clock. Each accepted word is written unchanged to the current byte address. The address then moves on by four bytes. The RAM holds 32K words, which is 128 KB. When the final word location has been written, the block sends a single-cycle full pulse to a supervisory controller. It then freezes the address and stops writing.

Capture only proceeds while two enables are both high. The source-side enable marks valid words. The host-side enable is the global run permission. After the host has drained the RAM, it starts the next capture by raising its enable, either from low to high or by dropping it and raising it again. That rising edge puts the address back at the base and clears the frozen state. The clock cycle in which the edge is seen is spent re-arming, and no write takes place in it.

Top module: `capbuf_wr_ctrl`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, the address is 0, the full pulse is low and write enable is low, as long as no enable is asserted.
- R2: Write enable is high exactly when the local enable and the global enable are both high, the buffer is not frozen, and the current cycle is not a re-arm cycle.
- R3: The write data output always equals the 32-bit input word, bit for bit.
- R4: After a cycle with write enable high at an address below the last one, the address is 4 higher. After a cycle with write enable low and no re-arm, the address is unchanged.
- R5: The full pulse is high for exactly one cycle. That cycle is the one right after the write to the last byte address, which is DEPTH_WORDS*4-4 (0x1FFFC by default).
- R6: After the last write, the address stays at the last byte address and write enable stays low, whatever the local enable does, until a re-arm.
- R7: A re-arm cycle is a clock in which the global enable is high after having been low at the previous clock; the global enable counts as low before the first clock after reset. In a re-arm cycle there is no write, the next address is 0, and the buffer is no longer frozen.
- R8: Between a re-arm and the next full pulse, exactly DEPTH_WORDS writes take place, which is 32768 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| local_en_i | input | 1 | The source's word is valid this cycle |
| global_en_i | input | 1 | Host run permission; a rising edge re-arms capture |
| data_i | input | 32 | Word produced by the source |
| wr_addr_o | output | 17 | RAM byte address for the write |
| wr_data_o | output | 32 | RAM write data |
| wr_en_o | output | 1 | RAM write strobe |
| full_o | output | 1 | One-cycle pulse after the last location is written |

## Verification
The address is driven straight from the counter register. A wrong step or a missed hold therefore shows on wr_addr_o in the very next cycle. If the frozen state is wrong, write enable rises while the buffer is full, or stays low after a re-arm, and either one is visible in the same cycle as the bad state. A full pulse that is early or late shows up as a count other than 32768 writes between a re-arm and the pulse. That can only be seen at the end of a whole fill, so the bench runs full fills.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
  typedef enum logic {
    CAP_ARMED  = 1'b0,
    CAP_FROZEN = 1'b1
  } cap_state_e;
endpackage

// File: rtl/capbuf_rearm_detect.sv
module capbuf_rearm_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic global_en_i,
  output logic rearm_o
);
  logic global_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) global_q <= 1'b0;
    else         global_q <= global_en_i;
  end

  assign rearm_o = global_en_i & ~global_q;

  // a re-arm can only follow a cycle in which global was low
  assert_rearm_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_o |=> !rearm_o || !$past(global_en_i) == 1'b0 ? !rearm_o : 1'b1);
endmodule

// File: rtl/capbuf_addr_gen.sv
module capbuf_addr_gen
  import capbuf_pkg::*;
#(
  parameter int unsigned DEPTH_WORDS = 32768,
  localparam int unsigned ADDR_W = $clog2(DEPTH_WORDS) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              rearm_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              frozen_o,
  output logic              at_last_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'((DEPTH_WORDS - 1) * 4);
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(4);

  logic [ADDR_W-1:0] addr_q;
  cap_state_e        state_q;

  assign at_last_o = (addr_q == LAST_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      state_q <= CAP_ARMED;
    end else if (rearm_i) begin
      addr_q  <= '0;
      state_q <= CAP_ARMED;
    end else if (we_i) begin
      if (at_last_o) state_q <= CAP_FROZEN;   // saturate, no wrap
      else           addr_q  <= addr_q + STEP;
    end
  end

  assign addr_o   = addr_q;
  assign frozen_o = (state_q == CAP_FROZEN);

  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !rearm_i && !at_last_o) |=> addr_q == $past(addr_q) + STEP);
  assert_addr_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !rearm_i) |=> $stable(addr_q));
  assert_frozen_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_o && !rearm_i) |=> (frozen_o && addr_q == LAST_ADDR));
  assert_rearm_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> (addr_q == '0 && !frozen_o));
endmodule

// File: rtl/capbuf_full_pulse.sv
module capbuf_full_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic last_write_i,
  output logic full_o
);
  logic full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) full_q <= 1'b0;
    else         full_q <= last_write_i;
  end

  assign full_o = full_q;

  // the last write freezes the buffer, so the pulse cannot repeat
  assert_full_one_shot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> !full_o);
endmodule

// File: rtl/capbuf_wr_ctrl.sv
module capbuf_wr_ctrl #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned DEPTH_WORDS = 32768,
  localparam int unsigned ADDR_W     = $clog2(DEPTH_WORDS) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              local_en_i,
  input  logic              global_en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_en_o,
  output logic              full_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'((DEPTH_WORDS - 1) * 4);

  logic rearm;
  logic frozen;
  logic at_last;
  logic we;

  capbuf_rearm_detect u_rearm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .global_en_i(global_en_i),
    .rearm_o    (rearm)
  );

  assign we = local_en_i & global_en_i & ~frozen & ~rearm;

  capbuf_addr_gen #(.DEPTH_WORDS(DEPTH_WORDS)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we),
    .rearm_i  (rearm),
    .addr_o   (wr_addr_o),
    .frozen_o (frozen),
    .at_last_o(at_last)
  );

  capbuf_full_pulse u_full (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .last_write_i(we & at_last),
    .full_o      (full_o)
  );

  assign wr_en_o   = we;
  assign wr_data_o = data_i;

  assert_no_write_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen |-> !wr_en_o);
  assert_no_write_rearm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm |-> !wr_en_o);
  assert_full_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> ($past(wr_en_o) && $past(wr_addr_o) == LAST_ADDR));
  assert_write_needs_enables_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (local_en_i && global_en_i));
endmodule

// File: tb/capbuf_wr_ctrl_tb_top.sv
`timescale 1ns/1ps
module capbuf_wr_ctrl_tb_top;
  localparam int unsigned DEPTH = 32768;
  localparam logic [16:0] LAST  = 17'h1FFFC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        l_en = 1'b0;
  logic        g_en = 1'b0;
  logic [31:0] din = '0;
  logic [16:0] wr_addr;
  logic [31:0] wr_data;
  logic        wr_en;
  logic        full;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [16:0] m_addr = '0;
  bit          m_frozen = 1'b0;
  bit          m_full = 1'b0;
  bit          m_prev_g = 1'b0;
  int          wr_count = 0;
  int          fills = 0;

  always #2 clk = ~clk;

  capbuf_wr_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .local_en_i(l_en), .global_en_i(g_en),
    .data_i(din), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_en_o(wr_en), .full_o(full)
  );

  function automatic bit exp_we(bit l, bit g);
    bit rearm = g & ~m_prev_g;
    return l & g & ~m_frozen & ~rearm;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check, then advance model at posedge
  task automatic step(bit l, bit g);
    bit we, rearm;
    @(negedge clk);
    l_en = l; g_en = g; din = $urandom;
    #1;
    rearm = g & ~m_prev_g;
    we    = exp_we(l, g);
    chk("R2 wr_en", 32'(wr_en), 32'(we));
    chk("R3 wr_data", wr_data, din);
    chk(m_frozen ? "R6 addr frozen" : "R4 addr", 32'(wr_addr), 32'(m_addr));
    chk("R5 full", 32'(full), 32'(m_full));
    if (full) begin
      chk("R8 writes per fill", wr_count, DEPTH);
      fills++;
    end
    if (wr_en) wr_count++;
    if (rearm) wr_count = 0;
    m_full = we && (m_addr == LAST);
    if (rearm) begin
      m_addr = '0; m_frozen = 1'b0;
    end else if (we) begin
      if (m_addr == LAST) m_frozen = 1'b1;
      else m_addr = m_addr + 17'd4;
    end
    m_prev_g = g;
    if (rearm) begin
      @(posedge clk); #1;
      chk("R7 rearm addr", 32'(wr_addr), 0);
    end
  endtask

  initial begin
    int start_fills;
    $urandom(32'h5EED_1234);
    #1;
    chk("R1 reset addr", 32'(wr_addr), 0);
    chk("R1 reset full", 32'(full), 0);
    chk("R1 reset wr_en", 32'(wr_en), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 post reset addr", 32'(wr_addr), 0);
    chk("R1 post reset wr_en", 32'(wr_en), 0);

    // global low: no writes, address holds
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    // directed full fill at full rate (first cycle is a re-arm)
    for (int i = 0; i < DEPTH + 4; i++) step(1'b1, 1'b1);
    chk("R5 fill seen", fills, 1);
    // frozen: wiggle local enable
    for (int i = 0; i < 20; i++) step(1'($urandom), 1'b1);
    // re-arm, then a mid-capture drop and re-arm
    step(1'b1, 1'b0);
    for (int i = 0; i < 50; i++) step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    chk("R7 rearm mid capture", 32'(wr_addr), 0);
    // random mix with occasional global drops
    for (int i = 0; i < 3000; i++)
      step(($urandom % 5) != 0, ($urandom % 200) != 0);
    // random-rate fill with global held high
    step(1'b0, 1'b0);
    start_fills = fills;
    for (int i = 0; i < 60000 && fills == start_fills; i++)
      step(($urandom % 4) != 0, 1'b1);
    chk("R8 random fill completed", fills, start_fills + 1);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule